// File: doc/BRIEF.md
# Barrier Release Multicast Replicator

This block sits inside a mesh router and spreads barrier-release packets back over the tree that the matching acquire packets formed. While acquires flow toward the master node, the block records in a small per-barrier bitmap every input port that an acquire for that barrier came in on. When a release for that barrier later reaches the router, one copy goes out on each recorded port, and the bitmap is then wiped. No packet carries a destination list.

There are five router ports, indexed local = 0, east = 1, south = 2, west = 3, north = 4. There are ten barrier ids, 0 to 9, each with a five-bit port record. A separate copier serves each input port. It looks up the record for the release waiting on that port. One release is granted per cycle. Copies appear in the same cycle that the release is presented, and they are handed to the output buffers through a valid/ready pair on each output.

Top module: `barrier_release_fanout`

## Requirements
- R1: After reset all port records are empty, and relInReady, relOutValid and errPulse are all low while no release is presented.
- R2: An acquire seen on port p (acqValid[p] high for one cycle) with id k in 0..9 sets bit p of record k. Bits from different ports and different cycles accumulate.
- R3: A granted release for id k with a non-empty record drives relOutValid equal to record k (bit i is port i) in the same cycle. Every driven copy carries id k on relOutId, and relInReady is high for the granted input.
- R4: Once a release for id k is accepted, record k is empty from the next cycle. A second release for k is then treated as empty.
- R5: A release whose target outputs are not all ready produces no copies and leaves relInReady low. The record is kept, and the release goes out whole once every target is ready.
- R6: A release for an empty record is accepted (relInReady high) with no copies. errPulse is then high for exactly the following cycle.
- R7: If an acquire for id k arrives in the same cycle that a release for k is accepted, the record is cleared first and the new acquire bit is kept.
- R8: When several inputs present releases, only the lowest-indexed one is granted in a cycle. The others see relInReady low.
- R9: Acquire ids of 10 or above change no record. A release with id 10 or above is handled as an empty record, as in R6.
- R10: Records for different ids are independent. Accepting a release for one id leaves every other record unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| acqValid | input | 5 | Acquire packet observed on each input port |
| acqId | input | 20 | Barrier id of each observed acquire, 4 bits per port, port i at bits [4i+3:4i] |
| relInValid | input | 5 | Release packet present on each input port |
| relInId | input | 20 | Barrier id of each release, 4 bits per port |
| relInReady | output | 5 | Release accepted on that input this cycle |
| relOutValid | output | 5 | Release copy offered to each output buffer |
| relOutId | output | 20 | Barrier id carried by each copy, 4 bits per port |
| relOutReady | input | 5 | Output buffer can take a copy |
| errPulse | output | 1 | One-cycle flag: a release hit an empty record |

## Verification
The assertions assume that a release is presented only after all of its barrier's acquires have crossed the router, apart from the deliberate same-cycle overlap case. They also assume that inputs change only between clock edges. The stimulus keeps to this: inputs are driven on the falling edge, and every release follows the acquires it depends on by at least one cycle, except in the R7 scenario. Releases for empty or out-of-range records are driven on purpose to exercise the drop path. The bench never changes relOutReady while it expects a stall to hold.

// File: rtl/bfan_pkg.sv
package bfan_pkg;
  localparam int NPORT = 5;
  localparam int NBAR  = 10;
  localparam int IDW   = $clog2(NBAR);
  localparam int SELW  = $clog2(NPORT);

  // strobes from control to datapath
  typedef struct packed {
    logic            fire;  // copies go out, record cleared
    logic            drop;  // release hit an empty record
    logic [SELW-1:0] sel;   // granted input port
  } relStrobe_t;
endpackage

// File: rtl/bfan_datapath.sv
module bfan_datapath
  import bfan_pkg::*;
#(
  parameter int NP  = NPORT,
  parameter int NB  = NBAR,
  parameter int IW  = IDW
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NP-1:0]             acqValid,
  input  logic [NP*IW-1:0]          acqId,
  input  logic [NP*IW-1:0]          relInId,
  input  relStrobe_t                strobe,
  output logic [NP-1:0][NP-1:0]     copyMask,
  output logic [NP-1:0]             relOutValid,
  output logic [NP*IW-1:0]          relOutId,
  output logic                      errPulse
);
  logic [NB-1:0][NP-1:0] statusQ;
  logic [NB-1:0][NP-1:0] setHit;
  logic [NB-1:0]         clrHit;
  logic [IW-1:0]         acqIdA [NP];
  logic [IW-1:0]         relIdA [NP];
  logic [IW-1:0]         selId;
  logic                  errQ;

  for (genvar p = 0; p < NP; p++) begin : g_unpack
    assign acqIdA[p] = acqId[p*IW +: IW];
    assign relIdA[p] = relInId[p*IW +: IW];
  end

  assign selId = relIdA[strobe.sel];

  // per-barrier set and clear events
  for (genvar b = 0; b < NB; b++) begin : g_bar
    for (genvar p = 0; p < NP; p++) begin : g_port
      assign setHit[b][p] = acqValid[p] && (int'(acqIdA[p]) == b);
    end
    assign clrHit[b] = strobe.fire && (int'(selId) == b);

    always_ff @(posedge clk) begin
      if (!rstN) statusQ[b] <= '0;
      else       statusQ[b] <= (statusQ[b] & ~{NP{clrHit[b]}}) | setHit[b];
    end
  end

  // one copier per input port: look up the record for its waiting release
  for (genvar p = 0; p < NP; p++) begin : g_copier
    always_comb begin
      copyMask[p] = '0;
      for (int b = 0; b < NB; b++) begin
        if (int'(relIdA[p]) == b) copyMask[p] = statusQ[b];
      end
    end
  end

  assign relOutValid = strobe.fire ? copyMask[strobe.sel] : '0;
  for (genvar p = 0; p < NP; p++) begin : g_outid
    assign relOutId[p*IW +: IW] = selId;
  end

  always_ff @(posedge clk) begin
    if (!rstN) errQ <= 1'b0;
    else       errQ <= strobe.drop;
  end
  assign errPulse = errQ;

  // R2
  for (genvar p = 0; p < NP; p++) begin : g_acq_chk
    acq_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      (acqValid[p] && int'(acqIdA[p]) < NB) |=> statusQ[$past(acqIdA[p])][p]);
  end

  // R4
  record_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fire && int'(selId) < NB && setHit[selId] == '0)
      |=> statusQ[$past(selId)] == '0);
endmodule

// File: rtl/bfan_ctrl.sv
module bfan_ctrl
  import bfan_pkg::*;
#(
  parameter int NP = NPORT
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NP-1:0]         relInValid,
  input  logic [NP-1:0]         relOutReady,
  input  logic [NP-1:0][NP-1:0] copyMask,
  output relStrobe_t            strobe,
  output logic [NP-1:0]         relInReady
);
  logic            anyReq;
  logic [SELW-1:0] sel;
  logic [NP-1:0]   selMask;
  logic            allReady;
  logic            emptyRec;

  // fixed priority: lowest index wins
  always_comb begin
    anyReq = 1'b0;
    sel    = '0;
    for (int i = NP - 1; i >= 0; i--) begin
      if (relInValid[i]) begin
        anyReq = 1'b1;
        sel    = SELW'(i);
      end
    end
  end

  assign selMask  = copyMask[sel];
  assign allReady = (selMask & ~relOutReady) == '0;
  assign emptyRec = selMask == '0;

  assign strobe.sel  = sel;
  assign strobe.fire = anyReq && !emptyRec && allReady;
  assign strobe.drop = anyReq && emptyRec;

  always_comb begin
    relInReady = '0;
    if (strobe.fire || strobe.drop) relInReady[sel] = 1'b1;
  end

  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(relInReady));

  // R8
  grant_lowest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (relInReady != '0) |-> ((relInValid & (relInReady - 1'b1)) == '0));
endmodule

// File: rtl/barrier_release_fanout.sv
module barrier_release_fanout
  import bfan_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NPORT-1:0]     acqValid,
  input  logic [NPORT*IDW-1:0] acqId,
  input  logic [NPORT-1:0]     relInValid,
  input  logic [NPORT*IDW-1:0] relInId,
  output logic [NPORT-1:0]     relInReady,
  output logic [NPORT-1:0]     relOutValid,
  output logic [NPORT*IDW-1:0] relOutId,
  input  logic [NPORT-1:0]     relOutReady,
  output logic                 errPulse
);
  relStrobe_t                  strobe;
  logic [NPORT-1:0][NPORT-1:0] copyMask;

  bfan_ctrl #(.NP(NPORT)) u_ctrl (
    .clk(clk), .rstN(rstN), .relInValid(relInValid),
    .relOutReady(relOutReady), .copyMask(copyMask),
    .strobe(strobe), .relInReady(relInReady)
  );

  bfan_datapath #(.NP(NPORT), .NB(NBAR), .IW(IDW)) u_dp (
    .clk(clk), .rstN(rstN), .acqValid(acqValid), .acqId(acqId),
    .relInId(relInId), .strobe(strobe), .copyMask(copyMask),
    .relOutValid(relOutValid), .relOutId(relOutId), .errPulse(errPulse)
  );

  // R5
  atomic_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (relOutValid & ~relOutReady) == '0);

  // R3
  copy_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (relOutValid != '0) |-> ((relInValid & relInReady) != '0));

  // R6
  drop_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (((relInValid & relInReady) != '0) && relOutValid == '0) |=> errPulse);

  // R6
  err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(((relInValid & relInReady) != '0) && relOutValid == '0));
endmodule

// File: tb/barrier_release_fanout_bench.sv
module barrier_release_fanout_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  acqValid = '0;
  logic [3:0]  acqIdA [5];
  logic [4:0]  relInValid = '0;
  logic [3:0]  relIdA [5];
  logic [4:0]  relOutReady = '1;
  logic [19:0] acqIdF, relInIdF, relOutIdF;
  logic [4:0]  relInReady, relOutValid;
  logic        errPulse;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  for (genvar g = 0; g < 5; g++) begin : g_pack
    assign acqIdF[g*4 +: 4]   = acqIdA[g];
    assign relInIdF[g*4 +: 4] = relIdA[g];
  end

  barrier_release_fanout u_barrier_release_fanout (
    .clk(clk), .rstN(rstN), .acqValid(acqValid), .acqId(acqIdF),
    .relInValid(relInValid), .relInId(relInIdF), .relInReady(relInReady),
    .relOutValid(relOutValid), .relOutId(relOutIdF),
    .relOutReady(relOutReady), .errPulse(errPulse)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // move to the next falling edge and clear all stimulus
  task automatic idle();
    @(negedge clk);
    acqValid   = '0;
    relInValid = '0;
  endtask

  task automatic acq(input int p, input int id);
    acqValid[p] = 1'b1;
    acqIdA[p]   = 4'(id);
  endtask

  task automatic rel(input int p, input int id);
    relInValid[p] = 1'b1;
    relIdA[p]     = 4'(id);
  endtask

  // sample combinational outputs mid-cycle
  task automatic expectRel(input string req, input int rdy, input int outv, input int id);
    #2;
    chk(req, "relInReady", int'(relInReady), rdy);
    chk(req, "relOutValid", int'(relOutValid), outv);
    for (int i = 0; i < 5; i++)
      if (outv[i]) chk(req, "relOutId", int'(relOutIdF[i*4 +: 4]), id);
  endtask

  task automatic expectErr(input string req, input int e);
    #2;
    chk(req, "errPulse", int'(errPulse), e);
  endtask

  task automatic tReset();
    #2;
    chk("R1", "relInReady", int'(relInReady), 0);
    chk("R1", "relOutValid", int'(relOutValid), 0);
    chk("R1", "errPulse", int'(errPulse), 0);
    idle();
    rel(0, 0);  // R1: every record starts empty
    expectRel("R1", 5'b00001, 0, 0);
    idle();
    expectErr("R1", 1);
    idle();
    expectErr("R1", 0);
  endtask

  task automatic tBasic();  // R2 R3 R4 R6
    idle(); acq(0, 3);
    idle(); acq(2, 3);
    idle(); rel(1, 3);
    expectRel("R3", 5'b00010, 5'b00101, 3);
    idle(); expectErr("R3", 0);
    rel(1, 3);  // R4: record must be empty now
    expectRel("R4", 5'b00010, 0, 0);
    idle(); expectErr("R6", 1);
    idle(); expectErr("R6", 0);
  endtask

  task automatic tStall();  // R5
    idle(); acq(3, 5); acq(4, 5);
    idle(); relOutReady = 5'b01111; rel(0, 5);
    expectRel("R5", 0, 0, 5);
    idle(); rel(0, 5);
    expectRel("R5", 0, 0, 5);
    idle(); relOutReady = 5'b11000; rel(0, 5);
    expectRel("R5", 5'b00001, 5'b11000, 5);
    idle(); relOutReady = '1;
  endtask

  task automatic tCollide();  // R7
    idle(); acq(1, 7);
    idle(); rel(0, 7); acq(2, 7);
    expectRel("R7", 5'b00001, 5'b00010, 7);
    idle(); rel(0, 7);
    expectRel("R7", 5'b00001, 5'b00100, 7);
    idle();
  endtask

  task automatic tPriority();  // R8
    idle(); acq(0, 1); acq(4, 2);
    idle(); rel(3, 2); rel(1, 1);
    expectRel("R8", 5'b00010, 5'b00001, 1);
    idle(); rel(3, 2);
    expectRel("R8", 5'b01000, 5'b10000, 2);
    idle();
  endtask

  task automatic tRange();  // R9
    idle(); acq(0, 12);
    idle(); rel(2, 12);
    expectRel("R9", 5'b00100, 0, 12);
    idle(); expectErr("R9", 1);
    rel(2, 2);  // id 12 aliases nothing: id 2 is still empty
    expectRel("R9", 5'b00100, 0, 2);
    idle();
  endtask

  task automatic tIndep();  // R10 R2
    idle(); acq(1, 4); acq(3, 4);
    idle(); acq(1, 6);
    idle(); rel(0, 6);
    expectRel("R10", 5'b00001, 5'b00010, 6);
    idle(); rel(4, 4);
    expectRel("R10", 5'b10000, 5'b01010, 4);
    idle();
  endtask

  initial begin
    for (int i = 0; i < 5; i++) begin acqIdA[i] = '0; relIdA[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tBasic();
    tStall();
    tCollide();
    tPriority();
    tRange();
    tIndep();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule